// File: doc/BRIEF.md
# Serial SAR ADC Readout Controller

This block sits on the host side of a three-wire link to a low-power successive-approximation converter. On a start request it pulls chip-select low and produces a serial clock, which the converter also uses to run its conversion. It then shifts in the frame. Each frame opens with four guard bits that must be zero, and the conversion result follows with its most significant bit first. The converter samples its input when chip-select falls. It freezes that sample on the third clock edge on which it drives data. Between frames it powers itself down, so the controller only has to keep chip-select high.

The result width is a parameter (12, 10 or 8 bits, straight binary). A clock-division parameter sets the SCLK half period in system clocks, so it sets the SCLK rate. An idle parameter sets the minimum time chip-select spends high between frames, and with the division it sets the highest frame rate. A polarity parameter selects which SCLK edge captures data. The converter changes its data output on the other edge. A good frame produces a one-cycle valid strobe together with the parallel code. A frame whose guard bits are not all zero sets a sticky error flag and produces no strobe.

Top module: `adc_frame_reader`

## Requirements
- R1: After synchronous reset, csN is 1, sclk is at its idle level, resultValid is 0, frameErr is 0 and resultCode is 0.
- R2: When startReq is 1 in the idle state, csN goes low on the next clock edge. sclk then stays at its idle level for CLK_DIV further clocks before the first bit cycle begins.
- R3: A frame has exactly 4 + RES_BITS SCLK cycles. csN stays low for CLK_DIV*(2*(4+RES_BITS)+1) clocks. sclk is at its idle level whenever csN is high.
- R4: With SAMPLE_RISE=1, sclk idles high, each bit is captured on the rising edge and the converter changes data on the falling edge. With SAMPLE_RISE=0, sclk idles low and both edges are swapped.
- R5: The first four captured bits are guard bits and are discarded. The next RES_BITS bits form resultCode, with the first of them as bit RES_BITS-1 (straight binary, MSB first).
- R6: resultValid is a single-cycle pulse on the clock edge at which csN returns high, and resultCode carries the new code in that same cycle.
- R7: If any guard bit is 1, frameErr is set to 1, no resultValid pulse follows that frame, and resultCode keeps its previous value.
- R8: Once set, frameErr stays 1 across later good frames until reset.
- R9: startReq is ignored while a frame is in progress and during the idle gap that follows it. Such a request starts no extra frame.
- R10: After each frame csN stays high for at least IDLE_CYCLES+1 clocks. This is exactly IDLE_CYCLES+1 when startReq is held high.
- R11: RES_BITS may be 12, 10 or 8, and the frame length and result width follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request one conversion frame |
| sdataIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Chip-select to the converter, active low |
| sclk | output | 1 | Serial and conversion clock to the converter |
| resultCode | output | RES_BITS | Last good conversion code |
| resultValid | output | 1 | One-cycle strobe for a new code |
| frameErr | output | 1 | Sticky flag for a nonzero guard bit |

## Verification
The bench builds two instances side by side. The first uses a 12-bit result, rising-edge capture, a two-clock half period and a three-clock idle gap. The second uses an 8-bit result, falling-edge capture, a one-clock half period and a two-clock gap. Between them they cover both clock polarities, the longest and shortest frames, and the tightest SCLK timing, where data is launched only one system clock before it is captured. Each instance is paired with a behavioural converter model that can corrupt a guard bit, which exercises the error path at both widths.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int LEAD_ZEROS = 4;

  typedef struct packed {
    logic clearFrame;
    logic captureBit;
    logic leadBit;
    logic finish;
  } ctl_strobe_t;
endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int CLK_DIV     = 2,
  parameter int IDLE_CYCLES = 3,
  parameter bit SAMPLE_RISE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  output logic        csN,
  output logic        sclk,
  output ctl_strobe_t strb
);
  localparam int FRAME_BITS = LEAD_ZEROS + RES_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS) + 1;
  localparam int HALF_W     = $clog2(CLK_DIV) + 1;
  localparam int GAP_W      = $clog2(IDLE_CYCLES) + 1;
  localparam logic IDLE_LVL = SAMPLE_RISE;

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_LAUNCH, ST_SAMPLE, ST_GAP} state_t;

  state_t            state;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              halfEnd;
  logic              lastBit;

  assign halfEnd = (halfCnt == HALF_W'(CLK_DIV - 1));
  assign lastBit = (bitCnt == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      csN     <= 1'b1;
      sclk    <= IDLE_LVL;
      halfCnt <= '0;
      bitCnt  <= '0;
      gapCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state   <= ST_LEAD;
          csN     <= 1'b0;
          halfCnt <= '0;
          bitCnt  <= '0;
        end
        ST_LEAD: if (halfEnd) begin
          state   <= ST_LAUNCH;
          sclk    <= ~IDLE_LVL;
          halfCnt <= '0;
        end else halfCnt <= halfCnt + 1'b1;
        ST_LAUNCH: if (halfEnd) begin
          state   <= ST_SAMPLE;
          sclk    <= IDLE_LVL;
          halfCnt <= '0;
        end else halfCnt <= halfCnt + 1'b1;
        ST_SAMPLE: if (halfEnd) begin
          halfCnt <= '0;
          if (lastBit) begin
            state  <= ST_GAP;
            csN    <= 1'b1;
            gapCnt <= '0;
          end else begin
            state  <= ST_LAUNCH;
            sclk   <= ~IDLE_LVL;
            bitCnt <= bitCnt + 1'b1;
          end
        end else halfCnt <= halfCnt + 1'b1;
        ST_GAP: if (gapCnt == GAP_W'(IDLE_CYCLES - 1)) state <= ST_IDLE;
                else gapCnt <= gapCnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clearFrame = (state == ST_IDLE) && startReq;
    strb.captureBit = (state == ST_LAUNCH) && halfEnd;
    strb.leadBit    = (bitCnt < BIT_W'(LEAD_ZEROS));
    strb.finish     = (state == ST_SAMPLE) && halfEnd && lastBit;
  end

  // R3: the clock rests at its idle level whenever chip-select is high
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
    csN |-> (sclk == IDLE_LVL));

  // R3: never more than the frame's bit count
  assert_bit_bound_R3: assert property (@(posedge clk) disable iff (rst)
    bitCnt < BIT_W'(FRAME_BITS));

  // R9: a frame only opens from idle on a request
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> ($past(state) == ST_IDLE && $past(startReq)));
endmodule

// File: rtl/adc_rd_dp.sv
module adc_rd_dp
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  ctl_strobe_t         strb,
  input  logic                sdataIn,
  output logic [RES_BITS-1:0] resultCode,
  output logic                resultValid,
  output logic                frameErr
);
  logic [RES_BITS-1:0] shiftReg;
  logic                frameBad;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg    <= '0;
      resultCode  <= '0;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
      frameBad    <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (strb.clearFrame) frameBad <= 1'b0;
      if (strb.captureBit) begin
        if (strb.leadBit) begin
          if (sdataIn) begin
            frameBad <= 1'b1;
            frameErr <= 1'b1;
          end
        end else begin
          shiftReg <= {shiftReg[RES_BITS-2:0], sdataIn};
        end
      end
      if (strb.finish && !frameBad) begin
        resultCode  <= shiftReg;
        resultValid <= 1'b1;
      end
    end
  end

  // R8: the error flag never clears outside reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> frameErr);

  // R7: a frame with a bad guard bit never raises the strobe
  assert_no_valid_bad_R7: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> !frameBad);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int CLK_DIV     = 2,
  parameter int IDLE_CYCLES = 3,
  parameter bit SAMPLE_RISE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic                sdataIn,
  output logic                csN,
  output logic                sclk,
  output logic [RES_BITS-1:0] resultCode,
  output logic                resultValid,
  output logic                frameErr
);
  ctl_strobe_t strb;

  adc_rd_ctrl #(
    .RES_BITS(RES_BITS), .CLK_DIV(CLK_DIV),
    .IDLE_CYCLES(IDLE_CYCLES), .SAMPLE_RISE(SAMPLE_RISE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq),
    .csN(csN), .sclk(sclk), .strb(strb)
  );

  adc_rd_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .sdataIn(sdataIn),
    .resultCode(resultCode), .resultValid(resultValid), .frameErr(frameErr)
  );

  // R6: the strobe appears only in the cycle chip-select has just risen
  assert_valid_at_cs_rise_R6: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (csN && !$past(csN)));
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_conv_model #(
  parameter int N = 12,
  parameter bit SAMPLE_RISE = 1'b1
) (
  input  logic         csN,
  input  logic         sclk,
  input  logic [N-1:0] code,
  input  logic         forceLead,
  output logic         sdata
);
  int idx;
  logic [N-1:0] held;
  initial begin sdata = 1'b0; idx = 0; held = '0; end
  always @(negedge csN) begin idx = 0; held = code; sdata = 1'b0; end
  always @(sclk) begin
    if (csN === 1'b0 && sclk === ~SAMPLE_RISE) begin
      if (idx == 2) held = code;
      if (idx < 4) sdata = forceLead && (idx == 2);
      else if (idx < N + 4) sdata = held[N + 3 - idx];
      else sdata = 1'b0;
      idx = idx + 1;
    end
  end
endmodule

module adc_frame_reader_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic startA = 0, startB = 0, sdA, sdB, csA, csB, sclkA, sclkB;
  logic validA, validB, errA, errB, forceA = 0, forceB = 0;
  logic [11:0] codeA = '0, resA;
  logic [7:0]  codeB = '0, resB;

  adc_frame_reader #(.RES_BITS(12), .CLK_DIV(2), .IDLE_CYCLES(3), .SAMPLE_RISE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .startReq(startA), .sdataIn(sdA), .csN(csA), .sclk(sclkA),
    .resultCode(resA), .resultValid(validA), .frameErr(errA));
  adc_frame_reader #(.RES_BITS(8), .CLK_DIV(1), .IDLE_CYCLES(2), .SAMPLE_RISE(1'b0)) u_dut_b (
    .clk(clk), .rst(rst), .startReq(startB), .sdataIn(sdB), .csN(csB), .sclk(sclkB),
    .resultCode(resB), .resultValid(validB), .frameErr(errB));

  adc_conv_model #(.N(12), .SAMPLE_RISE(1'b1)) u_modA (
    .csN(csA), .sclk(sclkA), .code(codeA), .forceLead(forceA), .sdata(sdA));
  adc_conv_model #(.N(8), .SAMPLE_RISE(1'b0)) u_modB (
    .csN(csB), .sclk(sclkB), .code(codeB), .forceLead(forceB), .sdata(sdB));

  int lowA, lowB, edgA, edgB, fallA, fallB;
  initial begin lowA = 0; lowB = 0; edgA = 0; edgB = 0; fallA = 0; fallB = 0; end
  always @(negedge csA) begin lowA = 0; edgA = 0; fallA = fallA + 1; end
  always @(negedge csB) begin lowB = 0; edgB = 0; fallB = fallB + 1; end
  always @(negedge clk) begin
    if (csA === 1'b0) lowA = lowA + 1;
    if (csB === 1'b0) lowB = lowB + 1;
  end
  always @(sclkA) if (csA === 1'b0 && sclkA === 1'b1) edgA = edgA + 1;
  always @(sclkB) if (csB === 1'b0 && sclkB === 1'b0) edgB = edgB + 1;

  function automatic logic csOf(int s);       return s != 0 ? csB : csA; endfunction
  function automatic logic validOf(int s);    return s != 0 ? validB : validA; endfunction
  function automatic logic errOf(int s);      return s != 0 ? errB : errA; endfunction
  function automatic logic [11:0] resOf(int s); return s != 0 ? {4'b0, resB} : resA; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart(int s);
    @(negedge clk);
    if (s != 0) startB = 1; else startA = 1;
    @(negedge clk);
    startA = 0; startB = 0;
  endtask

  task automatic waitCsHigh(int s);
    for (int i = 0; i < 1000 && csOf(s) !== 1'b1; i++) @(negedge clk);
  endtask

  // one frame; checks strobe, code, frame length and edge count
  task automatic runFrame(int s, logic [11:0] code, logic bad, logic [11:0] expCode);
    if (s != 0) begin codeB = code[7:0]; forceB = bad; end
    else begin codeA = code; forceA = bad; end
    pulseStart(s);
    check("R2 csN low after start", {31'b0, csOf(s)}, 0);
    waitCsHigh(s);
    check("R6/R7 valid strobe", {31'b0, validOf(s)}, {31'b0, ~bad});
    check("R5/R11 result code", {20'b0, resOf(s)}, {20'b0, expCode});
    check("R3/R4 sample edges", s != 0 ? edgB : edgA, s != 0 ? 12 : 16);
    check("R3 csN low clocks", s != 0 ? lowB : lowA, s != 0 ? 25 : 66);
    @(negedge clk);
    check("R6 strobe one cycle", {31'b0, validOf(s)}, 0);
    repeat (6) @(negedge clk);
    forceA = 0; forceB = 0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R1 csN A", {31'b0, csA}, 1);
    check("R1 sclk idle A", {31'b0, sclkA}, 1);
    check("R1 sclk idle B", {31'b0, sclkB}, 0);
    check("R1 valid/err", {28'b0, validA, errA, validB, errB}, 0);
    check("R1 code", {12'b0, resA, resB}, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_codes();
    runFrame(0, 12'h000, 0, 12'h000);
    runFrame(0, 12'hFFF, 0, 12'hFFF);
    runFrame(0, 12'hA5C, 0, 12'hA5C);
    runFrame(0, 12'h555, 0, 12'h555);
    runFrame(1, 12'h000, 0, 12'h000);
    runFrame(1, 12'h0FF, 0, 12'h0FF);
    runFrame(1, 12'h081, 0, 12'h081);
    runFrame(1, 12'h03C, 0, 12'h03C);
  endtask

  task automatic t_lead_err();
    runFrame(0, 12'h777, 1, 12'h555);
    check("R7 err A", {31'b0, errA}, 1);
    runFrame(0, 12'h123, 0, 12'h123);
    check("R8 err stays A", {31'b0, errA}, 1);
    runFrame(1, 12'h0EE, 1, 12'h03C);
    check("R7 err B", {31'b0, errB}, 1);
    runFrame(1, 12'h042, 0, 12'h042);
    check("R8 err stays B", {31'b0, errB}, 1);
  endtask

  task automatic t_ignore();
    int f0 = fallA;
    pulseStart(0);
    repeat (20) @(negedge clk);
    pulseStart(0);
    waitCsHigh(0);
    pulseStart(0);
    repeat (120) @(negedge clk);
    check("R9 one frame only", fallA - f0, 1);
    check("R9 csN idle", {31'b0, csA}, 1);
  endtask

  task automatic t_gap(int s);
    int hi = 0;
    @(negedge clk);
    if (s != 0) startB = 1; else startA = 1;
    for (int i = 0; i < 1000 && csOf(s) !== 1'b0; i++) @(negedge clk);
    waitCsHigh(s);
    for (int i = 0; i < 100 && csOf(s) === 1'b1; i++) begin hi = hi + 1; @(negedge clk); end
    check("R10 min gap", hi, s != 0 ? 3 : 4);
    startA = 0; startB = 0;
    waitCsHigh(s);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset_clears();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    check("R8 reset clears err", {30'b0, errA, errB}, 0);
    check("R1 reset csN", {30'b0, csA, csB}, 2'b11);
    rst = 0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1; errors = errors + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    t_reset();
    t_codes();
    t_lead_err();
    t_ignore();
    t_gap(0);
    t_gap(1);
    t_reset_clears();
    finishRun();
  end
endmodule